// File: doc/BRIEF.md
# Two-Way Victim Cache Tag Allocator

This block keeps the tags of a two-way set-associative second-level cache that holds only lines dropped by the first-level caches. Lines arrive in two ways. A data castout is a modified or clean line evicted from the first-level data cache. An instruction reload is a line being filled into the second level on behalf of the instruction side. For each request the block looks up both ways of the addressed set. It then decides whether to refresh a hit line, allocate a new tag, or send the line on to the system interface. Data RAM contents and demand-miss handling are not part of this block.

Each set carries one replacement bit that names the way to evict next. The bit is read when a fill actually takes place, and it flips to the opposite way each time a tag is allocated in that set. An allocation request flag gates allocation on a miss. A global enable makes the second level transparent: when it is clear, no state changes and modified castouts go straight to the system interface. All results are registered and appear one cycle after the request. A writeback request is raised when an allocation evicts a valid modified line.

Top module: `vca_top`

## Requirements
- R1: After reset every tag entry is invalid, every replacement bit is 0, and all outputs are 0, so the first allocation in any set uses way 0.
- R2: An enabled castout that misses with `reqAllocOk`=1 writes a tag and data into the way named by the set's replacement bit. The stored modified bit equals `reqModified`.
- R3: An enabled castout that misses with `reqAllocOk`=0 writes nothing. It raises `sysReqValid` with `sysReqAddr`=`reqAddr` exactly when `reqModified`=1.
- R4: An enabled castout that hits writes data and tag into the hit way whatever `reqAllocOk` is. It sets that line's modified bit to `reqModified`, leaves the replacement bit alone, and raises no system request.
- R5: With `l2Enable`=0 no tag or data write occurs and no stored state changes. A castout (`reqKind`=0) with `reqModified`=1 raises `sysReqValid` with its own address, and an instruction reload (`reqKind`=1) raises nothing.
- R6: Each allocation in a set inverts that set's replacement bit, and other sets are unaffected. Hits and non-allocating requests never change it.
- R7: An enabled instruction reload (`reqKind`=1) that hits reports `outHit` with the hit way and writes nothing. On a miss with `reqAllocOk`=1 it allocates a clean line with a data write. On a miss with `reqAllocOk`=0 it does nothing. It never passes its own address to the system interface.
- R8: An allocation whose victim is valid and modified raises `sysReqValid` with `sysReqAddr` = {victim tag, set index}. A clean or invalid victim raises no request.
- R9: `outValid` and all other outputs are registered and follow a request by exactly one clock. With no request they are 0, and back-to-back requests see every update made by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 1 | 0 = data castout, 1 = instruction reload |
| reqAddr | input | ADDR_W | Block address; low $clog2(SETS) bits select the set |
| reqModified | input | 1 | Castout line is modified |
| reqAllocOk | input | 1 | Allocation permitted on a miss |
| l2Enable | input | 1 | Second level enabled |
| outValid | output | 1 | Registered result present |
| outHit | output | 1 | Request hit a valid tag |
| outWay | output | 1 | Way hit or written (0 when neither) |
| outTagWrite | output | 1 | Tag entry was written |
| outDataWrite | output | 1 | Second-level data write strobe |
| sysReqValid | output | 1 | Castout or writeback to system interface |
| sysReqAddr | output | ADDR_W | Block address of the system request |

## Verification
The bench builds the block with SETS=4 and ADDR_W=5, so each set holds only eight possible tags. Every address × request kind × modified × allocate-flag × enable combination then fits in 512 requests. A short run fills sets completely and forces repeated evictions of dirty and clean victims. It also drives many flips of each replacement bit, with hits on lines written only a few requests earlier. A seeded random tail of mixed requests then compares every registered output against a small arithmetic model of tags and replacement bits kept in the bench.

// File: rtl/vca_pkg.sv
package vca_pkg;
  localparam int WAYS = 2;

  typedef enum logic {
    KIND_CASTOUT = 1'b0,
    KIND_IRELOAD = 1'b1
  } reqKindT;

  // Strobes from control into the tag datapath
  typedef struct packed {
    logic hit;       // lookup hit while enabled
    logic tagWr;     // write tag entry
    logic dataWr;    // second-level data write
    logic allocate;  // use victim way and flip replacement bit
    logic newMod;    // modified bit to store
    logic passOut;   // forward request address to system side
    logic evictWb;   // write back dirty victim
  } ctrlStrobesT;
endpackage

// File: rtl/vca_ctrl.sv
module vca_ctrl
  import vca_pkg::*;
(
  input  logic        reqValid,
  input  reqKindT     reqKind,
  input  logic        reqModified,
  input  logic        reqAllocOk,
  input  logic        l2Enable,
  input  logic        hitAny,
  input  logic        victimDirty,
  output ctrlStrobesT strobes
);
  logic isCastout;
  logic lookupOn;
  logic missAlloc;
  logic castHit;

  always_comb begin
    isCastout = (reqKind == KIND_CASTOUT);
    lookupOn  = reqValid && l2Enable;
    missAlloc = lookupOn && !hitAny && reqAllocOk;
    castHit   = lookupOn && hitAny && isCastout;

    strobes          = '0;
    strobes.hit      = lookupOn && hitAny;
    strobes.allocate = missAlloc;
    strobes.tagWr    = missAlloc || castHit;
    strobes.dataWr   = missAlloc || castHit;
    strobes.newMod   = isCastout ? reqModified : 1'b0;
    strobes.passOut  = reqValid && isCastout && reqModified &&
                       (!l2Enable || (!hitAny && !reqAllocOk));
    strobes.evictWb  = missAlloc && victimDirty;
  end
endmodule

// File: rtl/vca_tag_store.sv
module vca_tag_store
  import vca_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctrlStrobesT       strobes,
  output logic              hitAny,
  output logic              victimDirty,
  output logic              outValid,
  output logic              outHit,
  output logic              outWay,
  output logic              outTagWrite,
  output logic              outDataWrite,
  output logic              sysReqValid,
  output logic [ADDR_W-1:0] sysReqAddr
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;

  logic [SETS-1:0]  validQ [WAYS];
  logic [SETS-1:0]  modQ   [WAYS];
  logic [TAG_W-1:0] tagQ   [WAYS][SETS];
  logic [SETS-1:0]  fifoQ;

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WAYS-1:0]   hitVec;
  logic              hitWay;
  logic              victimWay;
  logic              wrWay;
  logic [ADDR_W-1:0] victimAddr;

  assign setIdx = reqAddr[SET_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : gWayCmp
    assign hitVec[w] = validQ[w][setIdx] && (tagQ[w][setIdx] == reqTag);
  end

  assign hitAny      = |hitVec;
  assign hitWay      = hitVec[1];
  assign victimWay   = fifoQ[setIdx];
  assign victimDirty = validQ[victimWay][setIdx] && modQ[victimWay][setIdx];
  assign victimAddr  = {tagQ[victimWay][setIdx], setIdx};
  assign wrWay       = strobes.allocate ? victimWay : hitWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        validQ[w] <= '0;
        modQ[w]   <= '0;
        for (int s = 0; s < SETS; s++) tagQ[w][s] <= '0;
      end
      fifoQ <= '0;
    end else if (strobes.tagWr) begin
      validQ[wrWay][setIdx] <= 1'b1;
      modQ[wrWay][setIdx]   <= strobes.newMod;
      tagQ[wrWay][setIdx]   <= reqTag;
      if (strobes.allocate) fifoQ[setIdx] <= ~fifoQ[setIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outHit       <= 1'b0;
      outWay       <= 1'b0;
      outTagWrite  <= 1'b0;
      outDataWrite <= 1'b0;
      sysReqValid  <= 1'b0;
      sysReqAddr   <= '0;
    end else begin
      outValid     <= reqValid;
      outHit       <= strobes.hit;
      outWay       <= (strobes.tagWr || strobes.hit) ? wrWay : 1'b0;
      outTagWrite  <= strobes.tagWr;
      outDataWrite <= strobes.dataWr;
      sysReqValid  <= strobes.passOut || strobes.evictWb;
      sysReqAddr   <= strobes.evictWb ? victimAddr :
                      (strobes.passOut ? reqAddr : '0);
    end
  end
endmodule

// File: rtl/vca_top.sv
module vca_top
  import vca_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqModified,
  input  logic              reqAllocOk,
  input  logic              l2Enable,
  output logic              outValid,
  output logic              outHit,
  output logic              outWay,
  output logic              outTagWrite,
  output logic              outDataWrite,
  output logic              sysReqValid,
  output logic [ADDR_W-1:0] sysReqAddr
);
  ctrlStrobesT strobes;
  logic        hitAny;
  logic        victimDirty;

  vca_ctrl uCtrl (
    .reqValid    (reqValid),
    .reqKind     (reqKindT'(reqKind)),
    .reqModified (reqModified),
    .reqAllocOk  (reqAllocOk),
    .l2Enable    (l2Enable),
    .hitAny      (hitAny),
    .victimDirty (victimDirty),
    .strobes     (strobes)
  );

  vca_tag_store #(.SETS(SETS), .ADDR_W(ADDR_W)) uStore (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqAddr      (reqAddr),
    .strobes      (strobes),
    .hitAny       (hitAny),
    .victimDirty  (victimDirty),
    .outValid     (outValid),
    .outHit       (outHit),
    .outWay       (outWay),
    .outTagWrite  (outTagWrite),
    .outDataWrite (outDataWrite),
    .sysReqValid  (sysReqValid),
    .sysReqAddr   (sysReqAddr)
  );
endmodule

// File: rtl/vca_checker.sv
module vca_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqKind,
  input logic reqModified,
  input logic reqAllocOk,
  input logic l2Enable,
  input logic outValid,
  input logic outHit,
  input logic outTagWrite,
  input logic outDataWrite,
  input logic sysReqValid
);
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !l2Enable) |=> (!outTagWrite && !outDataWrite)); // R5

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !l2Enable) |=> (sysReqValid == $past(!reqKind && reqModified))); // R5

  AST_NO_ALLOC_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && l2Enable && !reqAllocOk) |=> (outHit || !outTagWrite)); // R3

  AST_CASTOUT_HIT_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && l2Enable && !reqKind) |=> (!outHit || (outDataWrite && !sysReqValid))); // R4

  AST_RELOAD_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind) |=> (!sysReqValid || (outTagWrite && !outHit))); // R7

  AST_WB_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (sysReqValid && outTagWrite) |-> !outHit); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(outValid || outTagWrite || outDataWrite || sysReqValid)); // R9

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R9
endmodule

bind vca_top vca_checker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqKind      (reqKind),
  .reqModified  (reqModified),
  .reqAllocOk   (reqAllocOk),
  .l2Enable     (l2Enable),
  .outValid     (outValid),
  .outHit       (outHit),
  .outTagWrite  (outTagWrite),
  .outDataWrite (outDataWrite),
  .sysReqValid  (sysReqValid)
);

// File: tb/tb_vca_top.sv
module tb_vca_top;
  localparam int SETS   = 4;
  localparam int ADDR_W = 5;
  localparam int SET_W  = 2;
  localparam int TAG_W  = ADDR_W - SET_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqKind = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqModified = 1'b0;
  logic              reqAllocOk = 1'b0;
  logic              l2Enable = 1'b0;
  logic              outValid, outHit, outWay, outTagWrite, outDataWrite, sysReqValid;
  logic [ADDR_W-1:0] sysReqAddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference state derived from the requirements
  bit             mValid [2][SETS];
  bit             mMod   [2][SETS];
  bit [TAG_W-1:0] mTag   [2][SETS];
  bit             mFifo  [SETS];

  vca_top #(.SETS(SETS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqModified(reqModified), .reqAllocOk(reqAllocOk),
    .l2Enable(l2Enable), .outValid(outValid), .outHit(outHit), .outWay(outWay),
    .outTagWrite(outTagWrite), .outDataWrite(outDataWrite),
    .sysReqValid(sysReqValid), .sysReqAddr(sysReqAddr)
  );

  always #10 clk = ~clk;

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  // Drive one request just after a falling edge, check after the next falling edge
  task automatic doReq(bit kind, int addr, bit mdf, bit aok, bit en);
    int s = addr % SETS;
    bit [TAG_W-1:0] tg = TAG_W'(addr / SETS);
    bit hit = 0, hw = 0, alloc = 0, wr = 0, sysV = 0, way = 0, vw;
    int sysA = 0;
    string lbl;
    vw = mFifo[s];
    for (int w = 0; w < 2; w++)
      if (en && mValid[w][s] && mTag[w][s] == tg) begin hit = 1; hw = w[0]; end
    if (en && !hit && aok) alloc = 1;
    wr = alloc || (hit && !kind);
    if (hit || wr) way = alloc ? vw : hw;
    if (alloc && mValid[vw][s] && mMod[vw][s]) begin
      sysV = 1; sysA = int'(mTag[vw][s]) * SETS + s;
    end else if (!kind && mdf && (!en || (!hit && !aok))) begin
      sysV = 1; sysA = addr;
    end
    if (!en) lbl = "R5";
    else if (kind) lbl = "R7";
    else if (hit) lbl = "R4";
    else if (aok) lbl = sysV ? "R8" : "R2";
    else lbl = "R3";

    reqValid = 1'b1; reqKind = kind; reqAddr = ADDR_W'(addr);
    reqModified = mdf; reqAllocOk = aok; l2Enable = en;
    @(negedge clk);
    check("R9", "outValid", outValid, 1);
    check(lbl, "outHit", outHit, hit);
    check(lbl, "outTagWrite", outTagWrite, wr);
    check(lbl, "outDataWrite", outDataWrite, wr);
    check(alloc ? "R6" : lbl, "outWay", outWay, way);
    check(lbl, "sysReqValid", sysReqValid, sysV);
    if (sysV) check(lbl, "sysReqAddr", int'(sysReqAddr), sysA);
    if (wr) begin
      mValid[way][s] = 1; mMod[way][s] = kind ? 1'b0 : mdf; mTag[way][s] = tg;
    end
    if (alloc) mFifo[s] = ~mFifo[s];
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(negedge clk);
    check("R9", "idle outValid", outValid, 0);
    check("R9", "idle sysReqValid", sysReqValid, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        mValid[w][s] = 0; mMod[w][s] = 0; mTag[w][s] = '0;
      end
    for (int s = 0; s < SETS; s++) mFifo[s] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state of all outputs
    check("R1", "reset outValid", outValid, 0);
    check("R1", "reset outTagWrite", outTagWrite, 0);
    check("R1", "reset sysReqValid", sysReqValid, 0);
    check("R1", "reset outWay", outWay, 0);

    // R1: first fill in a set lands in way 0
    doReq(1'b0, 5, 1'b1, 1'b1, 1'b1);
    check("R1", "first victim way", outWay, 0);

    // R6/R8: fill one set repeatedly with dirty castouts to rotate ways
    for (int t = 0; t < 8; t++) doReq(1'b0, t * SETS + 2, t[0], 1'b1, 1'b1);
    idle();

    // Near-exhaustive sweep of the small configuration
    for (int a = 0; a < 32; a++)
      for (int k = 0; k < 2; k++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++)
            for (int e = 0; e < 2; e++)
              doReq(k[0], a, m[0], c[0], e[0]);
    idle();

    // Mixed random tail
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom(i + 7) & 32'h3ff);
      doReq(r[5], r[4:0], r[6], r[7], r[9:8] != 2'b00);
      if (r[9:7] == 3'b000) idle();
    end
    idle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule